// File: doc/BRIEF.md
# Vectored Fixed-Priority Interrupt Controller

This block sits next to a single-issue 8-bit core and decides, at each instruction boundary, whether the core must be diverted to an interrupt handler and to which address. It watches a configurable number of request lines. Each line is built either as an event source, which owns a sticky flag, or as a level source, which requests only while its condition is high. A per-source enable bit and one global enable bit gate every source. A soft reset request, which ignores all gating, sits above every source in rank.

When a request wins, the controller raises a one-cycle take strobe with the slot number and the handler address. The address is the table base plus two program words per slot: slot 0 is reset, source k uses slot k+1. A relocation input moves the table base from zero to a boot-section base set by a parameter. On the strobe the controller drops the global enable and clears the flag of the served event source. It follows the core's return, set-enable and clear-enable events. After a return it holds off new entries until one more instruction boundary has passed.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst_n` is low, flags, enables and the global enable are all zero. In the first cycle after `rst_n` goes high, `take` is 1 with `take_id` 0. The reset slot outranks any pending source.
- R2: Among enabled pending sources, the lowest index wins. `vec_addr` is the table base plus 2*(index+1).
- R3: A source is taken only in a cycle where `at_boundary`, its own enable bit and the global enable are all 1.
- R4: After a take the global enable is 0 on the next cycle. A cycle with `ret_evt` or `gie_set_evt`, and no take, sets it for the next cycle. `gie_clr_evt` clears it.
- R5: An event source's flag (sources with a 1 in `EVT_MASK`) is set in the cycle after any cycle with its request high. The flag stays set while the source is masked. The source is served once it is enabled. Hardware clears the flag in the cycle after the source is taken.
- R6: A one on a `flag_w1c` bit clears that event flag at the next edge. If the source's request is high in the same cycle, the flag stays set.
- R7: A level source (a 0 in `EVT_MASK`) requests only in cycles where its request input is high. Its `flags` bit always reads 0, and a condition that ends while the source is masked leaves nothing pending.
- R8: In the cycle of `ret_evt`, and at the first `at_boundary` cycle after it, no source is taken. The next boundary may take.
- R9: In a cycle with `gie_clr_evt` high, no source is taken, even when a request is ready in that same cycle.
- R10: With `vec_reloc` 1 the table base is `BOOT_BASE`; with 0 it is zero.
- R11: `take` is high for exactly one cycle per served request. `take_id` is 0 for reset and k+1 for source k.
- R12: A cycle with `rst_req` high causes a reset take (`take_id` 0) in the next cycle. This take ignores the enables, the global enable and `at_boundary`, and it clears the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rst_req | input | 1 | Soft reset request |
| src_req | input | N_SRC | Request lines, one per source |
| flag_w1c | input | N_SRC | Write-one-to-clear strobes for event flags |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | N_SRC | New per-source enable bits |
| vec_reloc | input | 1 | 1 moves the vector table to BOOT_BASE |
| at_boundary | input | 1 | Core is at an instruction boundary |
| ret_evt | input | 1 | Core executes return-from-interrupt |
| gie_set_evt | input | 1 | Core executes set-global-enable |
| gie_clr_evt | input | 1 | Core executes clear-global-enable |
| take | output | 1 | One-cycle strobe: divert the core now |
| take_id | output | $clog2(N_SRC+1) | Served slot, 0 = reset |
| vec_addr | output | ADDR_W | Handler address for the served slot |
| gie | output | 1 | Global enable bit |
| flags | output | N_SRC | Event flags (level sources read 0) |
| enables | output | N_SRC | Per-source enable bits |

## Verification
An exhaustive sweep drives all 256 request patterns over four event and four level sources. The table base alternates between both settings. The sweep compares the winning slot and address with a lowest-set-bit computation, which separates a correct rank order from an inverted or skewed one. After each take the flag picture shows that only the served event flag was cleared, and that level sources never left a flag. Directed sequences then place each gate against a ready request, one at a time: enable bit, global enable, boundary, the cycle of a clear-enable, and the hold after a return. These sequences tell a same-cycle block apart from a one-cycle-late one, and a one-boundary hold apart from no hold. Further sequences compare write-one-to-clear against a simultaneous request, and a masked event against a masked level.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Program words between two consecutive vector entries.
  localparam int unsigned VEC_STRIDE = 2;

  typedef enum logic [1:0] {
    GIE_HOLD  = 2'd0,
    GIE_CLEAR = 2'd1,
    GIE_SET   = 2'd2
  } gie_op_e;

  // Offset of a vector slot from the table base.
  function automatic int unsigned slot_offset(input int unsigned slot);
    return slot * VEC_STRIDE;
  endfunction

endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank #(
  parameter int unsigned          N_SRC    = 8,
  parameter logic [N_SRC-1:0]     EVT_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] flag_w1c,
  input  logic [N_SRC-1:0] served,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_wdata,
  output logic [N_SRC-1:0] flag_q,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (EVT_MASK[i]) begin : g_evt
      logic flag_r;
      // A new request outranks both clearing paths.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_r <= 1'b0;
        else        flag_r <= src_req[i] | (flag_r & ~flag_w1c[i] & ~served[i]);
      end
      assign flag_q[i] = flag_r;
      assign pend[i]   = flag_r;

      assert_flag_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        src_req[i] |=> flag_q[i]);
      assert_serve_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        served[i] && !src_req[i] |=> !flag_q[i]);
      assert_masked_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[i] && !served[i] && !flag_w1c[i] |=> flag_q[i]);
    end else begin : g_lvl
      logic unused_lvl_bits;
      assign unused_lvl_bits = flag_w1c[i] | served[i];
      assign flag_q[i] = 1'b0;
      assign pend[i]   = src_req[i];
    end
  end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] cand,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N_SRC-1:0] grant
);

  function automatic logic [IDX_W-1:0] first_one(input logic [N_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // Lowest index wins: a bit is granted when no lower bit is a candidate.
  for (genvar k = 0; k < N_SRC; k++) begin : g_grant
    if (k == 0) begin : g_top
      assign grant[k] = cand[k];
    end else begin : g_rest
      assign grant[k] = cand[k] & ~(|cand[k-1:0]);
    end
  end

  assign any = |cand;
  assign idx = first_one(cand);

endmodule

// File: rtl/irqc_gate.sv
module irqc_gate
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req,
  input  logic at_boundary,
  input  logic ret_evt,
  input  logic gie_set_evt,
  input  logic gie_clr_evt,
  input  logic src_ready,
  output logic take,
  output logic take_reset,
  output logic gie_q,
  output logic hold_q
);

  logic    rst_pend_q;
  logic    gie_open;
  logic    src_take;
  gie_op_e gie_op;

  // A clear-enable in this very cycle closes the gate at once.
  assign gie_open   = gie_q & ~gie_clr_evt;
  assign take_reset = rst_n & rst_pend_q;
  assign src_take   = rst_n & at_boundary & ~hold_q & ~ret_evt & gie_open
                      & src_ready & ~take_reset;
  assign take       = take_reset | src_take;

  always_comb begin
    if (take || gie_clr_evt)         gie_op = GIE_CLEAR;
    else if (gie_set_evt || ret_evt) gie_op = GIE_SET;
    else                             gie_op = GIE_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_q <= 1'b1;
      gie_q      <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      rst_pend_q <= rst_req | (rst_pend_q & ~take_reset);
      case (gie_op)
        GIE_CLEAR: gie_q <= 1'b0;
        GIE_SET:   gie_q <= 1'b1;
        default:   gie_q <= gie_q;
      endcase
      // One boundary must pass after a return before a source is entered.
      if (take_reset)       hold_q <= 1'b0;
      else if (ret_evt)     hold_q <= 1'b1;
      else if (at_boundary) hold_q <= 1'b0;
    end
  end

  assert_cli_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_evt |-> !take || take_reset);
  assert_one_instr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !take || take_reset);
  assert_gie_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie_q);
  assert_ret_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_evt && !take |=> gie_q);
  assert_reset_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> take && take_reset);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned        N_SRC     = 8,
  parameter logic [N_SRC-1:0]   EVT_MASK  = 'h0F,
  parameter int unsigned        ADDR_W    = 14,
  parameter logic [ADDR_W-1:0]  BOOT_BASE = 'h3800,
  localparam int unsigned       ID_W      = $clog2(N_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req,
  input  logic [N_SRC-1:0]  src_req,
  input  logic [N_SRC-1:0]  flag_w1c,
  input  logic              en_wr,
  input  logic [N_SRC-1:0]  en_wdata,
  input  logic              vec_reloc,
  input  logic              at_boundary,
  input  logic              ret_evt,
  input  logic              gie_set_evt,
  input  logic              gie_clr_evt,
  output logic              take,
  output logic [ID_W-1:0]   take_id,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              gie,
  output logic [N_SRC-1:0]  flags,
  output logic [N_SRC-1:0]  enables
);

  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0]  pend;
  logic [N_SRC-1:0]  en_q;
  logic [N_SRC-1:0]  cand;
  logic [N_SRC-1:0]  grant;
  logic [N_SRC-1:0]  served;
  logic [IDX_W-1:0]  win_idx;
  logic              win_any;
  logic              take_reset;
  logic              hold_q;
  logic              gie_q;
  logic [ADDR_W-1:0] table_base;

  irqc_src_bank #(.N_SRC(N_SRC), .EVT_MASK(EVT_MASK)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_req  (src_req),
    .flag_w1c (flag_w1c),
    .served   (served),
    .en_wr    (en_wr),
    .en_wdata (en_wdata),
    .flag_q   (flags),
    .en_q     (en_q),
    .pend     (pend)
  );

  assign cand = pend & en_q;

  irqc_arbiter #(.N_SRC(N_SRC)) u_arb (
    .cand  (cand),
    .any   (win_any),
    .idx   (win_idx),
    .grant (grant)
  );

  irqc_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_req     (rst_req),
    .at_boundary (at_boundary),
    .ret_evt     (ret_evt),
    .gie_set_evt (gie_set_evt),
    .gie_clr_evt (gie_clr_evt),
    .src_ready   (win_any),
    .take        (take),
    .take_reset  (take_reset),
    .gie_q       (gie_q),
    .hold_q      (hold_q)
  );

  assign served     = grant & {N_SRC{take & ~take_reset}};
  assign take_id    = take_reset ? '0 : ID_W'(win_idx) + ID_W'(1);
  assign table_base = vec_reloc ? BOOT_BASE : '0;
  assign vec_addr   = table_base + ADDR_W'(slot_offset(int'(take_id)));
  assign gie        = gie_q;
  assign enables    = en_q;

  assert_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && !take_reset |-> gie_q && at_boundary && en_q[win_idx] && pend[win_idx]);
  assert_no_higher_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && !take_reset |-> (cand & ((N_SRC'(1) << win_idx) - N_SRC'(1))) == '0);
  assert_single_serve_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(served));
  assert_no_hold_leak_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_evt |=> !take || take_reset);

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

  localparam int unsigned N_SRC = 8;
  localparam int unsigned ADDR_W = 14;
  localparam int unsigned BASE = 'h3800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req, en_wr, vec_reloc, at_boundary, ret_evt, gie_set_evt, gie_clr_evt;
  logic [N_SRC-1:0] src_req, flag_w1c, en_wdata;
  logic take, gie;
  logic [3:0] take_id;
  logic [ADDR_W-1:0] vec_addr;
  logic [N_SRC-1:0] flags, enables;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl #(
    .N_SRC(N_SRC), .EVT_MASK(8'h0F), .ADDR_W(ADDR_W), .BOOT_BASE(14'h3800)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .src_req(src_req),
    .flag_w1c(flag_w1c), .en_wr(en_wr), .en_wdata(en_wdata),
    .vec_reloc(vec_reloc), .at_boundary(at_boundary), .ret_evt(ret_evt),
    .gie_set_evt(gie_set_evt), .gie_clr_evt(gie_clr_evt), .take(take),
    .take_id(take_id), .vec_addr(vec_addr), .gie(gie), .flags(flags),
    .enables(enables)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rst_req = 0; src_req = '0; flag_w1c = '0; en_wr = 0; en_wdata = '0;
    at_boundary = 0; ret_evt = 0; gie_set_evt = 0; gie_clr_evt = 0;
  endtask

  task automatic next_cyc();
    @(negedge clk);
    idle();
  endtask

  function automatic int lowest(input int v);
    for (int i = N_SRC - 1; i >= 0; i--) if (v[i]) lowest = i;
    if (v == 0) lowest = -1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle();
    vec_reloc = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 flags in reset", int'(flags), 0);
    check("R1 enables in reset", int'(enables), 0);
    check("R1 gie in reset", int'(gie), 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset take", int'(take), 1);
    check("R1 reset id", int'(take_id), 0);
    check("R1 reset vector", int'(vec_addr), 0);
    next_cyc(); #1;
    check("R11 strobe one cycle", int'(take), 0);

    en_wr = 1; en_wdata = 8'hFF;
    next_cyc();

    // Exhaustive sweep: low nibble events, high nibble levels.
    for (int m = 0; m < 256; m++) begin
      int lo;
      int ef;
      lo = lowest(m);
      src_req = N_SRC'(m); gie_set_evt = 1; vec_reloc = (m % 3 == 0);
      next_cyc();
      src_req = N_SRC'(m & 'hF0); at_boundary = 1; #1;
      check("R5 event flags latched", int'(flags), m & 'h0F);
      check("R2 take", int'(take), (m != 0) ? 1 : 0);
      if (m != 0) begin
        check("R11 take id", int'(take_id), lo + 1);
        check("R2 R10 vector", int'(vec_addr), (vec_reloc ? BASE : 0) + 2 * (lo + 1));
      end
      next_cyc(); #1;
      check("R4 gie after take", int'(gie), (m == 0) ? 1 : 0);
      ef = m & 'h0F;
      if (lo >= 0 && lo < 4) ef = ef & ~(1 << lo);
      check("R5 R7 served flag cleared", int'(flags), ef);
      flag_w1c = '1;
      next_cyc();
    end
    vec_reloc = 0;

    // R3: per-source enable, global enable, boundary.
    en_wr = 1; en_wdata = 8'h04; src_req = 8'h05; gie_set_evt = 1;
    next_cyc(); at_boundary = 1; #1;
    check("R3 masked src0 skipped", int'(take_id), 3);
    check("R3 take", int'(take), 1);
    next_cyc(); #1;
    check("R5 masked flag kept", int'(flags), 'h01);
    gie_set_evt = 1;
    next_cyc(); #1;
    check("R3 no boundary no take", int'(take), 0);
    check("R4 set-enable", int'(gie), 1);
    at_boundary = 1; en_wr = 1; en_wdata = 8'h00; #1;
    check("R3 disabled source not taken", int'(take), 0);
    next_cyc(); en_wr = 1; en_wdata = 8'h01;
    next_cyc(); at_boundary = 1; #1;
    check("R5 served once enabled", int'(take_id), 1);
    check("R2 vector slot 1", int'(vec_addr), 2);
    next_cyc(); #1;
    check("R5 flag cleared on entry", int'(flags), 0);
    check("R4 gie dropped", int'(gie), 0);

    // R6: write-one-to-clear and request priority.
    src_req = 8'h02;
    next_cyc(); #1;
    check("R6 flag set", int'(flags), 'h02);
    flag_w1c = 8'h02;
    next_cyc(); #1;
    check("R6 w1c clears", int'(flags), 0);
    src_req = 8'h08;
    next_cyc(); src_req = 8'h08; flag_w1c = 8'h08;
    next_cyc(); #1;
    check("R6 request wins over w1c", int'(flags), 'h08);
    flag_w1c = 8'h08;
    next_cyc(); #1;
    check("R6 later w1c clears", int'(flags), 0);

    // R7: level source has no memory.
    en_wr = 1; en_wdata = 8'h00;
    next_cyc(); src_req = 8'h20; #1;
    check("R7 no flag for level", int'(flags), 0);
    next_cyc(); en_wr = 1; en_wdata = 8'h20; gie_set_evt = 1;
    next_cyc(); at_boundary = 1; #1;
    check("R7 vanished level not taken", int'(take), 0);
    next_cyc(); at_boundary = 1; src_req = 8'h20; vec_reloc = 1; #1;
    check("R7 live level taken", int'(take_id), 6);
    check("R10 relocated vector", int'(vec_addr), BASE + 12);
    next_cyc(); vec_reloc = 0;

    // R8: one instruction after return.
    src_req = 8'h01; en_wr = 1; en_wdata = 8'h01;
    next_cyc(); ret_evt = 1; at_boundary = 1; #1;
    check("R8 no take on return cycle", int'(take), 0);
    next_cyc(); #1;
    check("R4 return sets gie", int'(gie), 1);
    check("R8 idle cycle", int'(take), 0);
    at_boundary = 1; #1;
    check("R8 first boundary held", int'(take), 0);
    next_cyc(); at_boundary = 1; #1;
    check("R8 second boundary taken", int'(take_id), 1);
    next_cyc();

    // R9: clear-enable beats a same-cycle request.
    src_req = 8'h01; gie_set_evt = 1;
    next_cyc(); at_boundary = 1; gie_clr_evt = 1; #1;
    check("R9 same-cycle block", int'(take), 0);
    next_cyc(); #1;
    check("R9 gie cleared", int'(gie), 0);
    check("R9 flag still pending", int'(flags), 'h01);

    // R12/R1: soft reset outranks a ready source.
    gie_set_evt = 1; rst_req = 1;
    next_cyc(); at_boundary = 1; vec_reloc = 1; #1;
    check("R1 reset outranks source", int'(take_id), 0);
    check("R12 reset take", int'(take), 1);
    check("R10 reset at boot base", int'(vec_addr), BASE);
    next_cyc(); vec_reloc = 0; #1;
    check("R12 gie cleared by reset take", int'(gie), 0);
    check("R11 no second strobe", int'(take), 0);
    rst_req = 1;
    next_cyc(); #1;
    check("R12 ignores gie and boundary", int'(take), 1);
    next_cyc();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule